// File: doc/BRIEF.md
# Variable-Length Instruction Sequencer

This block walks a word-addressed program memory and turns its stream of 16-bit words into whole instructions. Each instruction starts with an opcode word. Zero, one or two operand words follow it. The number of operand words depends on the category and sub-operation fields of the opcode. Once every word of an instruction has arrived, the block presents one decoded bundle. The bundle holds the opcode word, the address it was fetched from, the operand count, a literal-or-register flag for each operand, and the operand values. Register-index operands are reduced to five bits.

The memory side is a one-outstanding read port. A one-cycle request carries the address. A one-cycle valid pulse returns the data after one or more cycles. The output side is a valid/ready handshake. The block does not prefetch. It fetches the next opcode only after the current bundle has been taken, and a halt instruction ends fetching until reset. The block does not execute the instruction, compute jump targets or take interrupts.

Top module: `vli_sequencer`

## Requirements
- R1: While reset is asserted, `mem_req`, `dec_valid` and `halted` are low. The first request after reset reads address 0.
- R2: Opcode bit 1 is the most significant bit (bit 15 of the word). The condition field occupies word bits [15:12] and is carried only inside `dec_opcode`. The category is word bits [11:8] and appears on `dec_category`. The sub-operation field is word bits [7:2], and length decoding uses word bits [5:2]. Word bit 1 is the immediacy flag of operand 1 and word bit 0 is that of operand 2.
- R3: Categories 1 (arithmetic), 2 (logical) and 3 (compare) take exactly two operand words.
- R4: Category 4 (control flow) takes one operand word when word bits [5:4] are 00, and no operand word otherwise.
- R5: Category 5 (memory access) takes two operand words (target, then address) when word bit 3 is 1, and one operand word otherwise. When word bit 2 is 1 (pop or load), operand 1 is always a register index, whatever its immediacy flag says.
- R6: An operand is reported as immediate only if its immediacy flag is set and the operand exists. For an operand the instruction lacks, the flag reads 0 and the value reads 0.
- R7: A register-index operand is reported as the low five bits of its word, zero-extended. An immediate operand is reported unchanged.
- R8: Words are requested at consecutive addresses, one per word consumed. `dec_pc` is the address of the instruction's opcode word.
- R9: Categories 6 to 15 are presented as one-word instructions with `dec_illegal` high and zero operands. Fetching then continues with the next word.
- R10: Category 0 (halt) is presented with `dec_halt` high. Once it is accepted, `halted` stays high and no further request or bundle appears until reset.
- R11: While `dec_valid` is high and `dec_ready` is low, the bundle holds steady and no memory request is issued.
- R12: Any read latency of one cycle or more is handled correctly. A new request is never issued while a read is still outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | 16 | Word address of the request |
| mem_rvalid | input | 1 | One-cycle read data strobe |
| mem_rdata | input | 16 | Read data |
| dec_valid | output | 1 | Decoded bundle available |
| dec_ready | input | 1 | Consumer accepts the bundle |
| dec_pc | output | 16 | Address of the opcode word |
| dec_opcode | output | 16 | Opcode word as fetched |
| dec_category | output | 4 | Category field of the opcode |
| dec_nops | output | 2 | Number of operand words (0 to 2) |
| dec_imm1 | output | 1 | Operand 1 is an immediate |
| dec_imm2 | output | 1 | Operand 2 is an immediate |
| dec_opnd1 | output | 16 | Operand 1 value or register index |
| dec_opnd2 | output | 16 | Operand 2 value or register index |
| dec_illegal | output | 1 | Category code is undefined |
| dec_halt | output | 1 | Instruction is a halt |
| halted | output | 1 | Fetching has stopped after an accepted halt |

## Verification
The checks assume that memory raises `mem_rvalid` only for a request that is still outstanding, and only once for each request. One of them reports a stray strobe as a violation of R12. The bench memory model answers each request exactly once, after a programmable delay of one to three cycles. It accepts nothing new while a reply is pending. The consumer changes `dec_ready` only between clock edges. It holds ready low for several cycles on selected bundles so that the stall checks have something to observe.

// File: rtl/vli_pkg.sv
package vli_pkg;

  localparam int unsigned WORD_W    = 16;
  localparam int unsigned REG_IDX_W = 5;
  localparam int unsigned CAT_W     = 4;
  localparam int unsigned SUB_W     = 4;
  localparam int unsigned NOPS_W    = 2;

  typedef enum logic [CAT_W-1:0] {
    CAT_HALT  = 4'd0,
    CAT_ARITH = 4'd1,
    CAT_LOGIC = 4'd2,
    CAT_CMP   = 4'd3,
    CAT_FLOW  = 4'd4,
    CAT_MEM   = 4'd5
  } cat_e;

  typedef enum logic [1:0] {
    ST_REQ  = 2'd0,
    ST_WAIT = 2'd1,
    ST_OUT  = 2'd2,
    ST_HALT = 2'd3
  } seq_state_e;

  typedef struct packed {
    logic [NOPS_W-1:0] nops;
    logic              imm1;
    logic              imm2;
    logic              illegal;
    logic              halt;
  } op_info_t;

endpackage

// File: rtl/vli_opdecode.sv
module vli_opdecode
  import vli_pkg::*;
(
  input  logic [CAT_W-1:0] cat,
  input  logic [SUB_W-1:0] sub,
  input  logic [1:0]       imm_bits,
  output op_info_t         info
);

  logic [NOPS_W-1:0] nops;
  logic              force_reg1;
  logic              bad;
  logic              stop;

  always_comb begin
    nops       = '0;
    force_reg1 = 1'b0;
    bad        = 1'b0;
    stop       = 1'b0;
    case (cat)
      CAT_HALT:  stop = 1'b1;
      CAT_ARITH,
      CAT_LOGIC,
      CAT_CMP:   nops = NOPS_W'(2);
      CAT_FLOW:  nops = (sub[3:2] == 2'b00) ? NOPS_W'(1) : NOPS_W'(0);
      CAT_MEM: begin
        nops       = sub[1] ? NOPS_W'(2) : NOPS_W'(1);
        force_reg1 = sub[0];
      end
      default:   bad = 1'b1;
    endcase
  end

  always_comb begin
    info.nops    = nops;
    info.imm1    = (nops != '0) && imm_bits[1] && !force_reg1;
    info.imm2    = (nops == NOPS_W'(2)) && imm_bits[0];
    info.illegal = bad;
    info.halt    = stop;
  end

endmodule

// File: rtl/vli_fetch_ctl.sv
module vli_fetch_ctl
  import vli_pkg::*;
#(
  parameter int unsigned W        = WORD_W,
  parameter int unsigned RESET_PC = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mem_rvalid,
  input  logic          out_ready,
  input  op_info_t      new_info,
  output logic          mem_req,
  output logic [W-1:0]  pc,
  output logic          cap_op,
  output logic          cap_o1,
  output logic          cap_o2,
  output logic          out_valid,
  output logic          halted
);

  localparam logic [W-1:0] PC_INIT = W'(RESET_PC);

  seq_state_e        state_q, state_d;
  logic [W-1:0]      pc_q, pc_d;
  logic [NOPS_W-1:0] slot_q, slot_d;
  logic [NOPS_W-1:0] need_q, need_d;
  logic              stop_q, stop_d;
  logic              word_in;

  assign word_in = (state_q == ST_WAIT) && mem_rvalid;

  always_comb begin
    state_d = state_q;
    pc_d    = pc_q;
    slot_d  = slot_q;
    need_d  = need_q;
    stop_d  = stop_q;
    cap_op  = 1'b0;
    cap_o1  = 1'b0;
    cap_o2  = 1'b0;
    case (state_q)
      ST_REQ:  state_d = ST_WAIT;
      ST_WAIT: begin
        if (mem_rvalid) begin
          pc_d = pc_q + W'(1);
          if (slot_q == '0) begin
            cap_op = 1'b1;
            need_d = new_info.nops;
            stop_d = new_info.halt;
            if (new_info.nops == '0) begin
              state_d = ST_OUT;
            end else begin
              slot_d  = NOPS_W'(1);
              state_d = ST_REQ;
            end
          end else begin
            cap_o1 = (slot_q == NOPS_W'(1));
            cap_o2 = (slot_q == NOPS_W'(2));
            if (slot_q == need_q) begin
              state_d = ST_OUT;
            end else begin
              slot_d  = slot_q + NOPS_W'(1);
              state_d = ST_REQ;
            end
          end
        end
      end
      ST_OUT: begin
        if (out_ready) begin
          slot_d  = '0;
          state_d = stop_q ? ST_HALT : ST_REQ;
        end
      end
      default: state_d = ST_HALT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_REQ;
      pc_q    <= PC_INIT;
      slot_q  <= '0;
      need_q  <= '0;
      stop_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (word_in) pc_q <= pc_d;
      slot_q  <= slot_d;
      if (cap_op) begin
        need_q <= need_d;
        stop_q <= stop_d;
      end
    end
  end

  assign mem_req   = (state_q == ST_REQ) && rst_n;
  assign pc        = pc_q;
  assign out_valid = (state_q == ST_OUT);
  assign halted    = (state_q == ST_HALT);

  // R10: once halted, silent and stuck
  p_halt_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (!mem_req && !out_valid));
  p_halt_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);
  // R8: each consumed word moves the address by one
  p_pc_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    word_in |=> (pc_q == $past(pc_q) + W'(1)));
  // R11: a stalled bundle keeps the fetch side parked
  p_stall_park_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && !mem_req && $stable(pc_q)));
  // R12: read data arrives only for an outstanding request
  p_rvalid_expected_r12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rvalid |-> (state_q == ST_WAIT));

endmodule

// File: rtl/vli_bundle.sv
module vli_bundle
  import vli_pkg::*;
#(
  parameter int unsigned W     = WORD_W,
  parameter int unsigned IDX_W = REG_IDX_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap_op,
  input  logic         cap_o1,
  input  logic         cap_o2,
  input  logic [W-1:0] rdata,
  input  logic [W-1:0] fetch_pc,
  input  op_info_t     new_info,
  input  logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] op_word,
  output logic [W-1:0] op_pc,
  output op_info_t     info,
  output logic [W-1:0] opnd1,
  output logic [W-1:0] opnd2
);

  localparam int unsigned PAD_W = W - IDX_W;

  logic [W-1:0] word_q, word_d;
  logic [W-1:0] ipc_q, ipc_d;
  op_info_t     info_q, info_d;
  logic [W-1:0] o1_q, o1_d;
  logic [W-1:0] o2_q, o2_d;
  logic [W-1:0] reg_view;

  assign reg_view = {{PAD_W{1'b0}}, rdata[IDX_W-1:0]};

  always_comb begin
    word_d = word_q;
    ipc_d  = ipc_q;
    info_d = info_q;
    o1_d   = o1_q;
    o2_d   = o2_q;
    if (cap_op) begin
      word_d = rdata;
      ipc_d  = fetch_pc;
      info_d = new_info;
      o1_d   = '0;
      o2_d   = '0;
    end
    if (cap_o1) o1_d = info_q.imm1 ? rdata : reg_view;
    if (cap_o2) o2_d = info_q.imm2 ? rdata : reg_view;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      ipc_q  <= '0;
      info_q <= '0;
      o1_q   <= '0;
      o2_q   <= '0;
    end else begin
      if (cap_op) begin
        word_q <= word_d;
        ipc_q  <= ipc_d;
        info_q <= info_d;
      end
      if (cap_op || cap_o1) o1_q <= o1_d;
      if (cap_op || cap_o2) o2_q <= o2_d;
    end
  end

  assign op_word = word_q;
  assign op_pc   = ipc_q;
  assign info    = info_q;
  assign opnd1   = o1_q;
  assign opnd2   = o2_q;

  // R11: bundle contents frozen while the consumer stalls
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> ($stable(word_q) && $stable(o1_q) && $stable(o2_q) && $stable(ipc_q)));
  // R7: register operands never exceed the index range
  p_reg_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && info_q.nops != '0 && !info_q.imm1) |-> (o1_q[W-1:IDX_W] == '0));
  // R6: a missing second operand reads as zero register
  p_absent_op2_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && info_q.nops != NOPS_W'(2)) |-> (!info_q.imm2 && o2_q == '0));
  // R9: illegal opcodes carry no operands
  p_illegal_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && info_q.illegal) |-> (info_q.nops == '0 && o1_q == '0 && !info_q.imm1));

endmodule

// File: rtl/vli_sequencer.sv
module vli_sequencer
  import vli_pkg::*;
#(
  parameter int unsigned W        = WORD_W,
  parameter int unsigned IDX_W    = REG_IDX_W,
  parameter int unsigned RESET_PC = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              mem_req,
  output logic [W-1:0]      mem_addr,
  input  logic              mem_rvalid,
  input  logic [W-1:0]      mem_rdata,
  output logic              dec_valid,
  input  logic              dec_ready,
  output logic [W-1:0]      dec_pc,
  output logic [W-1:0]      dec_opcode,
  output logic [CAT_W-1:0]  dec_category,
  output logic [NOPS_W-1:0] dec_nops,
  output logic              dec_imm1,
  output logic              dec_imm2,
  output logic [W-1:0]      dec_opnd1,
  output logic [W-1:0]      dec_opnd2,
  output logic              dec_illegal,
  output logic              dec_halt,
  output logic              halted
);

  localparam int unsigned CAT_LSB = W - 8;
  localparam int unsigned SUB_LSB = 2;

  op_info_t     new_info;
  op_info_t     held_info;
  logic         cap_op, cap_o1, cap_o2;
  logic [W-1:0] fetch_pc;

  vli_opdecode u_dec (
    .cat      (mem_rdata[CAT_LSB +: CAT_W]),
    .sub      (mem_rdata[SUB_LSB +: SUB_W]),
    .imm_bits (mem_rdata[1:0]),
    .info     (new_info)
  );

  vli_fetch_ctl #(.W(W), .RESET_PC(RESET_PC)) u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .mem_rvalid (mem_rvalid),
    .out_ready  (dec_ready),
    .new_info   (new_info),
    .mem_req    (mem_req),
    .pc         (fetch_pc),
    .cap_op     (cap_op),
    .cap_o1     (cap_o1),
    .cap_o2     (cap_o2),
    .out_valid  (dec_valid),
    .halted     (halted)
  );

  vli_bundle #(.W(W), .IDX_W(IDX_W)) u_bun (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap_op    (cap_op),
    .cap_o1    (cap_o1),
    .cap_o2    (cap_o2),
    .rdata     (mem_rdata),
    .fetch_pc  (fetch_pc),
    .new_info  (new_info),
    .out_valid (dec_valid),
    .out_ready (dec_ready),
    .op_word   (dec_opcode),
    .op_pc     (dec_pc),
    .info      (held_info),
    .opnd1     (dec_opnd1),
    .opnd2     (dec_opnd2)
  );

  assign mem_addr     = fetch_pc;
  assign dec_category = dec_opcode[CAT_LSB +: CAT_W];
  assign dec_nops     = held_info.nops;
  assign dec_imm1     = held_info.imm1;
  assign dec_imm2     = held_info.imm2;
  assign dec_illegal  = held_info.illegal;
  assign dec_halt     = held_info.halt;

endmodule

// File: tb/test_vli_sequencer.sv
module test_vli_sequencer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mem_req;
  logic [15:0] mem_addr;
  logic        mem_rvalid;
  logic [15:0] mem_rdata;
  logic        dec_valid;
  logic        dec_ready = 1'b0;
  logic [15:0] dec_pc, dec_opcode, dec_opnd1, dec_opnd2;
  logic [3:0]  dec_category;
  logic [1:0]  dec_nops;
  logic        dec_imm1, dec_imm2, dec_illegal, dec_halt, halted;

  always #5 clk = ~clk;

  vli_sequencer i_vli_sequencer (
    .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .dec_valid(dec_valid),
    .dec_ready(dec_ready), .dec_pc(dec_pc), .dec_opcode(dec_opcode),
    .dec_category(dec_category), .dec_nops(dec_nops), .dec_imm1(dec_imm1),
    .dec_imm2(dec_imm2), .dec_opnd1(dec_opnd1), .dec_opnd2(dec_opnd2),
    .dec_illegal(dec_illegal), .dec_halt(dec_halt), .halted(halted)
  );

  int n_checks = 0;
  int n_bad    = 0;
  int cyc      = 0;

  logic [15:0] mem [0:63];
  int          lat = 1;
  logic        pend;
  int          pcnt;
  logic [15:0] paddr;
  logic [15:0] exp_addr;
  int          n_reqs;

  function automatic logic [15:0] mk(input logic [3:0] cond, input logic [3:0] cat,
                                     input logic [3:0] f4, input logic i1, input logic i2);
    return {cond, cat, 2'b00, f4, i1, i2};
  endfunction

  // memory model: one reply per request, after lat cycles
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_rvalid <= 1'b0;
      mem_rdata  <= '0;
      pend       <= 1'b0;
      pcnt       <= 0;
      paddr      <= '0;
      exp_addr   <= '0;
      n_reqs     = 0;
    end else begin
      mem_rvalid <= 1'b0;
      if (mem_req) begin
        n_reqs++;
        n_checks++;
        if (mem_addr !== exp_addr) begin
          n_bad++;
          $display("FAIL R8 fetch address act=%h exp=%h", mem_addr, exp_addr);
        end
        n_checks++;
        if (pend) begin
          n_bad++;
          $display("FAIL R12 request while read pending act=1 exp=0");
        end
        exp_addr <= exp_addr + 16'd1;
        if (lat <= 1) begin
          mem_rvalid <= 1'b1;
          mem_rdata  <= mem[mem_addr[5:0]];
        end else begin
          pend  <= 1'b1;
          pcnt  <= lat - 1;
          paddr <= mem_addr;
        end
      end else if (pend) begin
        if (pcnt <= 1) begin
          mem_rvalid <= 1'b1;
          mem_rdata  <= mem[paddr[5:0]];
          pend       <= 1'b0;
        end else begin
          pcnt <= pcnt - 1;
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      n_bad++;
      $display("FAIL R8 watchdog act=%0d exp<50000", cyc);
      $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 64; i++) mem[i] = 16'h0000;
  endtask

  // R1: reset state
  task automatic do_reset();
    rst_n     = 1'b0;
    dec_ready = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "mem_req in reset", {15'd0, mem_req}, 16'd0);
    chk("R1", "dec_valid in reset", {15'd0, dec_valid}, 16'd0);
    chk("R1", "halted in reset", {15'd0, halted}, 16'd0);
    rst_n = 1'b1;
  endtask

  task automatic expect_bundle(input string tag, input logic [15:0] pc, input logic [15:0] op,
                               input logic [1:0] nops, input logic i1, input logic i2,
                               input logic [15:0] o1, input logic [15:0] o2,
                               input logic ill, input logic hlt, input int stall);
    int waited = 0;
    while (!dec_valid && waited < 400) begin
      @(negedge clk);
      waited++;
    end
    if (!dec_valid) begin
      chk(tag, "bundle never valid", 16'd0, 16'd1);
      return;
    end
    chk("R8", "dec_pc", dec_pc, pc);
    chk("R2", "dec_opcode", dec_opcode, op);
    chk("R2", "dec_category", {12'd0, dec_category}, {12'd0, op[11:8]});
    chk(tag, "dec_nops", {14'd0, dec_nops}, {14'd0, nops});
    chk("R6", "dec_imm1", {15'd0, dec_imm1}, {15'd0, i1});
    chk("R6", "dec_imm2", {15'd0, dec_imm2}, {15'd0, i2});
    chk(tag, "dec_opnd1", dec_opnd1, o1);
    chk(tag, "dec_opnd2", dec_opnd2, o2);
    chk("R9", "dec_illegal", {15'd0, dec_illegal}, {15'd0, ill});
    chk("R10", "dec_halt", {15'd0, dec_halt}, {15'd0, hlt});
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      chk("R11", "valid during stall", {15'd0, dec_valid}, 16'd1);
      chk("R11", "opcode during stall", dec_opcode, op);
      chk("R11", "opnd1 during stall", dec_opnd1, o1);
      chk("R11", "mem_req during stall", {15'd0, mem_req}, 16'd0);
    end
    dec_ready = 1'b1;
    @(negedge clk);
    dec_ready = 1'b0;
  endtask

  task automatic expect_halted(input int words);
    logic ok = 1'b1;
    for (int c = 0; c < 30; c++) begin
      @(negedge clk);
      if (!halted || mem_req || dec_valid) ok = 1'b0;
    end
    chk("R10", "quiet after halt", {15'd0, ok}, 16'd1);
    chk("R8", "word requests", 16'(n_reqs), 16'(words));
  endtask

  // R2 R3 R6 R7 R8 R11: two-operand categories, one-cycle latency, stall
  task automatic t_two_operand();
    clear_mem();
    mem[0] = mk(4'h0, 4'd1, 4'd0, 1'b0, 1'b0); mem[1] = 16'h0025; mem[2] = 16'hFFE3;
    mem[3] = mk(4'h0, 4'd2, 4'd1, 1'b1, 1'b0); mem[4] = 16'h1234; mem[5] = 16'h0041;
    mem[6] = mk(4'hA, 4'd3, 4'd0, 1'b0, 1'b1); mem[7] = 16'h003F; mem[8] = 16'hBEEF;
    mem[9] = 16'h0000;
    lat = 1;
    do_reset();
    expect_bundle("R7", 16'd0, mem[0], 2'd2, 1'b0, 1'b0, 16'd5, 16'd3, 1'b0, 1'b0, 0);
    expect_bundle("R3", 16'd3, mem[3], 2'd2, 1'b1, 1'b0, 16'h1234, 16'd1, 1'b0, 1'b0, 5);
    expect_bundle("R3", 16'd6, mem[6], 2'd2, 1'b0, 1'b1, 16'd31, 16'hBEEF, 1'b0, 1'b0, 0);
    expect_bundle("R10", 16'd9, mem[9], 2'd0, 1'b0, 1'b0, 16'd0, 16'd0, 1'b0, 1'b1, 2);
    expect_halted(10);
  endtask

  // R4 R5 R6 R12: control flow and memory access, three-cycle latency
  task automatic t_flow_mem();
    clear_mem();
    mem[0]  = mk(4'h0, 4'd4, 4'd1, 1'b1, 1'b1); mem[1] = 16'h00FF;
    mem[2]  = mk(4'h0, 4'd4, 4'd4, 1'b1, 1'b1);
    mem[3]  = mk(4'h0, 4'd4, 4'd8, 1'b0, 1'b0);
    mem[4]  = mk(4'h0, 4'd5, 4'd0, 1'b1, 1'b0); mem[5] = 16'h7777;
    mem[6]  = mk(4'h0, 4'd5, 4'd1, 1'b1, 1'b0); mem[7] = 16'h0123;
    mem[8]  = mk(4'h0, 4'd5, 4'd3, 1'b1, 1'b1); mem[9] = 16'h0044; mem[10] = 16'h5555;
    mem[11] = mk(4'h0, 4'd5, 4'd2, 1'b1, 1'b0); mem[12] = 16'h9999; mem[13] = 16'h003E;
    mem[14] = 16'hF000;
    lat = 3;
    do_reset();
    expect_bundle("R4", 16'd0, mem[0], 2'd1, 1'b1, 1'b0, 16'h00FF, 16'd0, 1'b0, 1'b0, 0);
    expect_bundle("R4", 16'd2, mem[2], 2'd0, 1'b0, 1'b0, 16'd0, 16'd0, 1'b0, 1'b0, 0);
    expect_bundle("R4", 16'd3, mem[3], 2'd0, 1'b0, 1'b0, 16'd0, 16'd0, 1'b0, 1'b0, 3);
    expect_bundle("R5", 16'd4, mem[4], 2'd1, 1'b1, 1'b0, 16'h7777, 16'd0, 1'b0, 1'b0, 0);
    expect_bundle("R5", 16'd6, mem[6], 2'd1, 1'b0, 1'b0, 16'd3, 16'd0, 1'b0, 1'b0, 0);
    expect_bundle("R5", 16'd8, mem[8], 2'd2, 1'b0, 1'b1, 16'd4, 16'h5555, 1'b0, 1'b0, 0);
    expect_bundle("R12", 16'd11, mem[11], 2'd2, 1'b1, 1'b0, 16'h9999, 16'd30, 1'b0, 1'b0, 0);
    expect_bundle("R10", 16'd14, mem[14], 2'd0, 1'b0, 1'b0, 16'd0, 16'd0, 1'b0, 1'b1, 0);
    expect_halted(15);
  endtask

  // R9: undefined categories, two-cycle latency
  task automatic t_illegal();
    clear_mem();
    mem[0] = 16'h0603;
    mem[1] = 16'h0F00;
    mem[2] = mk(4'h0, 4'd1, 4'd0, 1'b0, 1'b0); mem[3] = 16'h0001; mem[4] = 16'h0002;
    mem[5] = 16'h0000;
    lat = 2;
    do_reset();
    expect_bundle("R9", 16'd0, mem[0], 2'd0, 1'b0, 1'b0, 16'd0, 16'd0, 1'b1, 1'b0, 0);
    expect_bundle("R9", 16'd1, mem[1], 2'd0, 1'b0, 1'b0, 16'd0, 16'd0, 1'b1, 1'b0, 0);
    expect_bundle("R3", 16'd2, mem[2], 2'd2, 1'b0, 1'b0, 16'd1, 16'd2, 1'b0, 1'b0, 0);
    expect_bundle("R10", 16'd5, mem[5], 2'd0, 1'b0, 1'b0, 16'd0, 16'd0, 1'b0, 1'b1, 0);
    expect_halted(6);
  endtask

  initial begin
    t_two_operand();
    t_flow_mem();
    t_illegal();
    $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end

endmodule